// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

After every synchronous reset, this block fetches a fixed 15-byte configuration image from a small two-wire serial EEPROM and places it in a set of shadow registers. The registers are a 64-bit unique ID, a maximum-latency byte, a minimum-grant byte, a 16-bit vendor identifier, a 16-bit subsystem identifier and three enable flags. The block has its own two-wire master. It sets the read pointer with a dummy write of address zero and then reads the whole image in one sequential burst.

While the load is running, the block raises `busy`, and every host bus slave request that arrives is answered with retry. If the device address byte gets no acknowledge, the EEPROM counts as absent. The loader then issues a stop, loads fixed defaults into the configuration fields and leaves `rom_present` low. If the image is loaded from the EEPROM, the unique ID is locked against software writes until the next reset. If no EEPROM answered, software may write the ID.

Top module: `cfg_rom_loader`

## Requirements
- R1: Loading starts by itself when `rst` (synchronous, active high) is released. `busy` is 1 during reset and stays 1 until the load ends. Asserting `rst` in the middle of a load abandons it, and the next load starts again from the first byte.
- R2: While `busy` is 1, `slv_retry` follows `slv_req`. While `busy` is 0, `slv_retry` is 0.
- R3: The bus sequence is: start, write address byte `{DEV_ADDR,0}`, pointer byte 0x00, repeated start, read address byte `{DEV_ADDR,1}`, then 15 data bytes, then stop. The master answers each of the first 14 data bytes with ACK (SDA low) and the last one with NACK (SDA released). Every SCL high phase lasts 2*QDIV clocks.
- R4: The image bytes map as follows. Byte 0 goes to `max_lat`. Bytes 1 and 2 are `vendor_id` low and high. Bytes 3 and 5 are `subsys_id` low and high. Byte 4 goes to `min_gnt`. Bits 7:5 of byte 6 go to `en_flags[2:0]`. Bytes 7 to 14 form `uid`, most significant byte first.
- R5: `uid` is all zeros after reset.
- R6: If the device address byte is not acknowledged, the loader issues one stop and does not read. It then sets `max_lat`=4, `min_gnt`=2, `vendor_id`=DFLT_VENDOR, `subsys_id`=DFLT_SUBSYS and `en_flags`=0.
- R7: `rom_present` is 1 exactly when the EEPROM acknowledged its address during the last load. In `ver_word`, bit 24 equals `rom_present` and every other bit is 0.
- R8: After a load from the EEPROM, writes to `uid` through `sw_we` have no effect on either half.
- R9: When no EEPROM answered and the block is idle, a write with `sw_sel`=1 sets `uid[63:32]` and a write with `sw_sel`=0 sets `uid[31:0]`. Writes made while `busy` is 1 have no effect.
- R10: When `busy` falls, `scl_o` is 1 and `sda_low_o` is 0. `busy` stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also starts a new load |
| scl_o | output | 1 | Serial clock to the EEPROM |
| sda_low_o | output | 1 | 1 pulls the open-drain data line low |
| sda_i | input | 1 | Level on the data line |
| slv_req | input | 1 | A host slave access is arriving |
| slv_retry | output | 1 | Answer the current slave access with retry |
| sw_we | input | 1 | Software write strobe for the unique ID |
| sw_sel | input | 1 | 1 selects the upper ID word, 0 the lower |
| sw_data | input | 32 | Software write data |
| busy | output | 1 | Load in progress |
| rom_present | output | 1 | EEPROM acknowledged during the last load |
| ver_word | output | 32 | Version status word, bit 24 = ROM present |
| uid | output | 64 | Unique ID |
| vendor_id | output | 16 | Vendor identifier |
| subsys_id | output | 16 | Subsystem identifier |
| max_lat | output | 8 | Maximum latency field |
| min_gnt | output | 8 | Minimum grant field |
| en_flags | output | 3 | Enable bits from image byte 6 |

## Verification
The loader is run against an EEPROM model that holds two different image patterns. Because each byte has its own value, a wrong byte order, a swapped half or a shifted bit shows up as a field mismatch. A run with the EEPROM absent separates the default path from the loaded path, and it also checks that the ID then accepts writes while a loaded ID refuses them. A reset in the middle of a load tells a clean restart apart from a resumed or doubled transaction. The model counts address bytes, ACKs, NACKs and stops for this purpose.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {TW_START, TW_STOP, TW_WRITE, TW_READ} tw_op_e;

  typedef enum logic [3:0] {
    SQ_START, SQ_DEVW, SQ_PTR, SQ_RSTART, SQ_DEVR,
    SQ_READ, SQ_STOP, SQ_FIN, SQ_DONE
  } seq_st_e;

  localparam int unsigned IMG_BYTES = 15;
  localparam int unsigned IDX_W     = $clog2(IMG_BYTES);
  localparam int unsigned UID_BYTES = 8;
  localparam logic [7:0]  LAT_DFLT  = 8'd4;
  localparam logic [7:0]  GNT_DFLT  = 8'd2;
endpackage

// File: rtl/cfgld_twi.sv
module cfgld_twi
  import cfgld_pkg::*;
#(
  parameter int unsigned QDIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  tw_op_e     cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_last,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_low_o,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_ok
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] div_q;
  logic          active;
  tw_op_e        op_q;
  logic [1:0]    ph;
  logic [3:0]    bit_q;
  logic [8:0]    sh_q;
  logic [8:0]    rx_q;
  logic          tick;
  logic          last_bit;

  // line pattern per quarter: {scl, sda_low}
  function automatic logic [1:0] pat(tw_op_e op, logic [1:0] p, logic b);
    logic [1:0] r;
    case (op)
      TW_START: case (p)
        2'd0: r = 2'b00;
        2'd1: r = 2'b10;
        2'd2: r = 2'b11;
        default: r = 2'b01;
      endcase
      TW_STOP: case (p)
        2'd0: r = 2'b01;
        2'd1: r = 2'b11;
        default: r = 2'b10;
      endcase
      default: case (p)
        2'd1, 2'd2: r = {1'b1, ~b};
        default: r = {1'b0, ~b};
      endcase
    endcase
    return r;
  endfunction

  assign tick     = active && (div_q == CW'(QDIV - 1));
  assign last_bit = (op_q == TW_START || op_q == TW_STOP) ? 1'b1 : (bit_q == 4'd8);
  assign rx_byte  = rx_q[8:1];
  assign ack_ok   = ~rx_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      div_q     <= '0;
      op_q      <= TW_STOP;
      ph        <= 2'd0;
      bit_q     <= 4'd0;
      sh_q      <= '1;
      rx_q      <= '0;
      scl_o     <= 1'b1;
      sda_low_o <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active <= 1'b1;
          div_q  <= '0;
          op_q   <= cmd_op;
          ph     <= 2'd0;
          bit_q  <= 4'd0;
          sh_q   <= (cmd_op == TW_WRITE) ? {cmd_byte, 1'b1} : {8'hFF, cmd_last};
          {scl_o, sda_low_o} <= pat(cmd_op, 2'd0,
                                    (cmd_op == TW_WRITE) ? cmd_byte[7] : 1'b1);
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (ph == 2'd2) rx_q <= {rx_q[7:0], sda_i};
          if (ph == 2'd3) begin
            if (last_bit) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_q <= bit_q + 4'd1;
              ph    <= 2'd0;
              sh_q  <= {sh_q[7:0], 1'b1};
              {scl_o, sda_low_o} <= pat(op_q, 2'd0, sh_q[7]);
            end
          end else begin
            ph <= ph + 2'd1;
            {scl_o, sda_low_o} <= pat(op_q, ph + 2'd1, sh_q[8]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tw_done,
  input  logic             tw_ack_ok,
  output logic             tw_valid,
  output tw_op_e           tw_op,
  output logic [7:0]       tw_byte,
  output logic             tw_last,
  output logic             ld_en,
  output logic [IDX_W-1:0] ld_idx,
  output logic             dflt_en,
  output logic             fin,
  output logic             busy,
  output logic             present
);
  seq_st_e st;
  logic    issued;

  always_comb begin
    tw_valid = !issued && !(st inside {SQ_FIN, SQ_DONE});
    case (st)
      SQ_START, SQ_RSTART:      tw_op = TW_START;
      SQ_DEVW, SQ_PTR, SQ_DEVR: tw_op = TW_WRITE;
      SQ_READ:                  tw_op = TW_READ;
      default:                  tw_op = TW_STOP;
    endcase
    case (st)
      SQ_DEVW: tw_byte = {DEV_ADDR, 1'b0};
      SQ_DEVR: tw_byte = {DEV_ADDR, 1'b1};
      default: tw_byte = 8'h00;
    endcase
    tw_last = (ld_idx == IDX_W'(IMG_BYTES - 1));
    ld_en   = (st == SQ_READ) && tw_done;
    dflt_en = (st == SQ_DEVW) && tw_done && !tw_ack_ok;
    fin     = (st == SQ_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_START;
      issued  <= 1'b0;
      ld_idx  <= '0;
      busy    <= 1'b1;
      present <= 1'b0;
    end else begin
      if (tw_valid) issued <= 1'b1;
      if (tw_done)  issued <= 1'b0;
      case (st)
        SQ_START:  if (tw_done) st <= SQ_DEVW;
        SQ_DEVW:   if (tw_done) begin
                     present <= tw_ack_ok;
                     st      <= tw_ack_ok ? SQ_PTR : SQ_STOP;
                   end
        SQ_PTR:    if (tw_done) st <= SQ_RSTART;
        SQ_RSTART: if (tw_done) st <= SQ_DEVR;
        SQ_DEVR:   if (tw_done) st <= SQ_READ;
        SQ_READ:   if (tw_done) begin
                     if (tw_last) st <= SQ_STOP;
                     else ld_idx <= ld_idx + 1'b1;
                   end
        SQ_STOP:   if (tw_done) st <= SQ_FIN;
        SQ_FIN:    begin
                     busy <= 1'b0;
                     st   <= SQ_DONE;
                   end
        default:   st <= SQ_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
  import cfgld_pkg::*;
#(
  parameter logic [15:0] DFLT_VENDOR = 16'h0000,
  parameter logic [15:0] DFLT_SUBSYS = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_byte,
  input  logic             dflt_en,
  input  logic             lock_en,
  input  logic             busy,
  input  logic             sw_we,
  input  logic             sw_sel,
  input  logic [31:0]      sw_data,
  output logic [63:0]      uid,
  output logic [15:0]      vendor_id,
  output logic [15:0]      subsys_id,
  output logic [7:0]       max_lat,
  output logic [7:0]       min_gnt,
  output logic [2:0]       en_flags
);
  logic locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      uid       <= '0;
      vendor_id <= '0;
      subsys_id <= '0;
      max_lat   <= '0;
      min_gnt   <= '0;
      en_flags  <= '0;
      locked    <= 1'b0;
    end else begin
      if (ld_en) begin
        case (ld_idx)
          IDX_W'(0): max_lat         <= ld_byte;
          IDX_W'(1): vendor_id[7:0]  <= ld_byte;
          IDX_W'(2): vendor_id[15:8] <= ld_byte;
          IDX_W'(3): subsys_id[7:0]  <= ld_byte;
          IDX_W'(4): min_gnt         <= ld_byte;
          IDX_W'(5): subsys_id[15:8] <= ld_byte;
          IDX_W'(6): en_flags        <= ld_byte[7:5];
          default: ;
        endcase
        for (int b = 0; b < UID_BYTES; b++) begin
          if (ld_idx == IDX_W'(IMG_BYTES - 1 - b)) uid[b*8 +: 8] <= ld_byte;
        end
      end
      if (dflt_en) begin
        max_lat   <= LAT_DFLT;
        min_gnt   <= GNT_DFLT;
        vendor_id <= DFLT_VENDOR;
        subsys_id <= DFLT_SUBSYS;
        en_flags  <= '0;
      end
      if (lock_en) locked <= 1'b1;
      if (sw_we && !busy && !locked) begin
        if (sw_sel) uid[63:32] <= sw_data;
        else        uid[31:0]  <= sw_data;
      end
    end
  end
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfgld_pkg::*;
#(
  parameter int unsigned QDIV        = 4,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter logic [15:0] DFLT_VENDOR = 16'h1B0C,
  parameter logic [15:0] DFLT_SUBSYS = 16'h7E55
) (
  input  logic        clk,
  input  logic        rst,
  output logic        scl_o,
  output logic        sda_low_o,
  input  logic        sda_i,
  input  logic        slv_req,
  output logic        slv_retry,
  input  logic        sw_we,
  input  logic        sw_sel,
  input  logic [31:0] sw_data,
  output logic        busy,
  output logic        rom_present,
  output logic [31:0] ver_word,
  output logic [63:0] uid,
  output logic [15:0] vendor_id,
  output logic [15:0] subsys_id,
  output logic [7:0]  max_lat,
  output logic [7:0]  min_gnt,
  output logic [2:0]  en_flags
);
  tw_op_e           tw_op;
  logic             tw_valid, tw_done, tw_ack_ok, tw_last;
  logic [7:0]       tw_byte, rx_byte;
  logic             ld_en, dflt_en, fin;
  logic [IDX_W-1:0] ld_idx;

  cfgld_twi #(.QDIV(QDIV)) u_twi (
    .clk(clk), .rst(rst), .cmd_valid(tw_valid), .cmd_op(tw_op),
    .cmd_byte(tw_byte), .cmd_last(tw_last), .sda_i(sda_i),
    .scl_o(scl_o), .sda_low_o(sda_low_o), .done(tw_done),
    .rx_byte(rx_byte), .ack_ok(tw_ack_ok)
  );

  cfgld_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk(clk), .rst(rst), .tw_done(tw_done), .tw_ack_ok(tw_ack_ok),
    .tw_valid(tw_valid), .tw_op(tw_op), .tw_byte(tw_byte), .tw_last(tw_last),
    .ld_en(ld_en), .ld_idx(ld_idx), .dflt_en(dflt_en), .fin(fin),
    .busy(busy), .present(rom_present)
  );

  cfgld_regs #(.DFLT_VENDOR(DFLT_VENDOR), .DFLT_SUBSYS(DFLT_SUBSYS)) u_regs (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(rx_byte),
    .dflt_en(dflt_en), .lock_en(fin && rom_present), .busy(busy),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
    .uid(uid), .vendor_id(vendor_id), .subsys_id(subsys_id),
    .max_lat(max_lat), .min_gnt(min_gnt), .en_flags(en_flags)
  );

  assign slv_retry = slv_req && busy;
  assign ver_word  = {7'd0, rom_present, 24'd0};
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        slv_req,
  input logic        slv_retry,
  input logic        scl_o,
  input logic        sda_low_o,
  input logic        rom_present,
  input logic [63:0] uid,
  input logic [7:0]  max_lat,
  input logic [7:0]  min_gnt
);
  AST_RETRY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && slv_req |-> slv_retry); // R2
  AST_NO_RETRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !slv_retry); // R2
  AST_UID_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> uid == 64'd0); // R5
  AST_ABSENT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    !busy && !rom_present |-> max_lat == 8'd4 && min_gnt == 8'd2); // R6
  AST_UID_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && rom_present && $past(!busy && rom_present)) |-> $stable(uid)); // R8
  AST_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> scl_o && !sda_low_o); // R10
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> !busy); // R10
endmodule

bind cfg_rom_loader cfgld_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .slv_req(slv_req), .slv_retry(slv_retry),
  .scl_o(scl_o), .sda_low_o(sda_low_o), .rom_present(rom_present),
  .uid(uid), .max_lat(max_lat), .min_gnt(min_gnt)
);

// File: tb/cfg_rom_loader_tb_top.sv
module cfgld_eeprom_model #(
  parameter logic [6:0] ADDR = 7'h50
) (
  input  logic             rst,
  input  logic             scl,
  input  logic             sda,
  input  logic             present,
  input  logic [7:0]       seed,
  output logic             pull,
  output int unsigned      n_wdev,
  output int unsigned      n_rdev,
  output int unsigned      n_ack,
  output int unsigned      n_nack,
  output int unsigned      n_stop,
  output int unsigned      ptr_seen
);
  function automatic logic [7:0] img(logic [7:0] s, int i);
    return s + 8'(i * 37);
  endfunction

  initial begin
    logic in_x, ackph, is_dev, rd, dev_r, nack_m, pscl, psda;
    int bc, ptr;
    logic [7:0] sh;
    pull = 0; in_x = 0; ackph = 0; is_dev = 0; rd = 0; dev_r = 0; nack_m = 0;
    bc = 0; ptr = 0; sh = 0; pscl = 1; psda = 1;
    n_wdev = 0; n_rdev = 0; n_ack = 0; n_nack = 0; n_stop = 0; ptr_seen = 999;
    forever begin
      @(rst or scl or sda);
      if (rst) begin
        pull = 0; in_x = 0; ackph = 0; rd = 0;
        n_wdev = 0; n_rdev = 0; n_ack = 0; n_nack = 0; n_stop = 0; ptr_seen = 999;
      end else if (scl && pscl && psda && !sda) begin
        in_x = 1; bc = 0; ackph = 0; is_dev = 1; rd = 0; pull = 0;
      end else if (scl && pscl && !psda && sda) begin
        n_stop++; in_x = 0; pull = 0;
      end else if (scl && !pscl && in_x) begin
        if (!ackph) begin
          if (!rd) sh = {sh[6:0], sda};
          bc++;
        end else if (rd) begin
          nack_m = sda;
          if (sda) n_nack++; else n_ack++;
        end
      end else if (!scl && pscl && in_x) begin
        if (!ackph && bc == 8) begin
          ackph = 1;
          if (rd) pull = 0;
          else if (is_dev) begin
            if (present && sh[7:1] == ADDR) begin
              pull = 1; dev_r = sh[0];
              if (sh[0]) n_rdev++; else n_wdev++;
            end else in_x = 0;
          end else begin
            ptr = int'(sh); ptr_seen = int'(sh); pull = 1;
          end
        end else if (ackph) begin
          ackph = 0; bc = 0;
          if (rd ? !nack_m : (is_dev && dev_r)) begin
            rd = 1; sh = img(seed, ptr); ptr++; pull = ~sh[7];
          end else begin
            pull = 0;
            if (rd) in_x = 0;
          end
          is_dev = 0;
        end else if (rd) begin
          sh = {sh[6:0], 1'b0}; pull = ~sh[7];
        end
      end
      pscl = scl; psda = sda;
    end
  end
endmodule

module cfg_rom_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [15:0] DV = 16'h1B0C;
  localparam logic [15:0] DS = 16'h7E55;

  logic clk = 0, rst = 1;
  logic slv_req = 0, sw_we = 0, sw_sel = 0;
  logic [31:0] sw_data = 0;
  logic present = 1;
  logic [7:0] seed = 8'h5A;
  logic scl, sdl, pull, busy, retry, rom_present;
  logic [31:0] ver_word;
  logic [63:0] uid;
  logic [15:0] vendor_id, subsys_id;
  logic [7:0] max_lat, min_gnt;
  logic [2:0] en_flags;
  int unsigned n_wdev, n_rdev, n_ack, n_nack, n_stop, ptr_seen;
  wire sda_line = !(sdl || pull);
  int checks = 0, errors = 0, bad_pulses = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_rom_loader #(.QDIV(QDIV), .DEV_ADDR(DEV), .DFLT_VENDOR(DV), .DFLT_SUBSYS(DS)) dut_i (
    .clk(clk), .rst(rst), .scl_o(scl), .sda_low_o(sdl), .sda_i(sda_line),
    .slv_req(slv_req), .slv_retry(retry), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_data(sw_data), .busy(busy), .rom_present(rom_present), .ver_word(ver_word),
    .uid(uid), .vendor_id(vendor_id), .subsys_id(subsys_id), .max_lat(max_lat),
    .min_gnt(min_gnt), .en_flags(en_flags)
  );

  cfgld_eeprom_model #(.ADDR(DEV)) mdl_i (
    .rst(rst), .scl(scl), .sda(sda_line), .present(present), .seed(seed),
    .pull(pull), .n_wdev(n_wdev), .n_rdev(n_rdev), .n_ack(n_ack), .n_nack(n_nack),
    .n_stop(n_stop), .ptr_seen(ptr_seen)
  );

  // SCL high-phase length monitor (R3)
  initial begin
    int hi; logic skip;
    hi = 0; skip = 1;
    forever begin
      @(negedge clk);
      if (rst) begin hi = 0; skip = 1; end
      else if (scl) hi++;
      else if (hi > 0) begin
        if (!skip && busy && hi != 2 * QDIV) bad_pulses++;
        skip = 0; hi = 0;
      end
    end
  end

  typedef struct { string req; int id; logic [63:0] exp; } exp_t;
  exp_t sb_q[$];
  event sb_ev;

  function automatic logic [63:0] probe(int id);
    case (id)
      0: return uid;
      1: return 64'(vendor_id);
      2: return 64'(subsys_id);
      3: return 64'(max_lat);
      4: return 64'(min_gnt);
      5: return 64'(en_flags);
      6: return 64'(rom_present);
      7: return 64'(busy);
      8: return 64'(ver_word);
      9: return 64'(retry);
      10: return 64'(scl && !sdl);
      11: return 64'(n_wdev);
      12: return 64'(n_rdev);
      13: return 64'(ptr_seen);
      14: return 64'(n_ack);
      15: return 64'(n_nack);
      16: return 64'(n_stop);
      default: return 64'(bad_pulses);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [63:0] act;
        it = sb_q.pop_front();
        act = probe(it.id);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s item=%0d actual=%h expected=%h", it.req, it.id, act, it.exp);
        end
      end
    end
  end

  task automatic push(string r, int id, logic [63:0] e);
    sb_q.push_back('{req: r, id: id, exp: e});
  endtask

  task automatic flush();
    -> sb_ev;
    wait (sb_q.size() == 0);
  endtask

  function automatic logic [7:0] img(logic [7:0] s, int i);
    return s + 8'(i * 37);
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 30000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(int n);
    @(negedge clk); rst = 1;
    repeat (n) @(negedge clk);
    rst = 0;
  endtask

  task automatic sw_write(logic sel, logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_sel = sel; sw_data = d;
    @(negedge clk); sw_we = 0;
    @(negedge clk);
  endtask

  task automatic expect_loaded(string tag, logic [7:0] s);
    logic [63:0] u;
    u = 0;
    for (int k = 0; k < 8; k++) u = {u[55:0], img(s, 7 + k)};
    push({tag, " R4 max_lat"}, 3, 64'(img(s, 0)));
    push({tag, " R4 vendor"}, 1, 64'({img(s, 2), img(s, 1)}));
    push({tag, " R4 subsys"}, 2, 64'({img(s, 5), img(s, 3)}));
    push({tag, " R4 min_gnt"}, 4, 64'(img(s, 4)));
    push({tag, " R4 en_flags"}, 5, 64'(img(s, 6) >> 5));
    push({tag, " R4 uid"}, 0, u);
    push({tag, " R7 present"}, 6, 64'd1);
    push({tag, " R7 ver_word"}, 8, 64'h0100_0000);
    push({tag, " R3 write addr acks"}, 11, 64'd1);
    push({tag, " R3 read addr acks"}, 12, 64'd1);
    push({tag, " R3 pointer"}, 13, 64'd0);
    push({tag, " R3 master ACKs"}, 14, 64'd14);
    push({tag, " R3 master NACKs"}, 15, 64'd1);
    push({tag, " R3 stops"}, 16, 64'd1);
    push({tag, " R3 scl high length"}, 17, 64'd0);
    push({tag, " R10 lines idle"}, 10, 64'd1);
    flush();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] u_keep;
    repeat (3) @(negedge clk);
    // reset state
    push("R5 uid at reset", 0, 64'd0);
    push("R1 busy in reset", 7, 64'd1);
    push("R7 present at reset", 6, 64'd0);
    flush();
    rst = 0;

    // R2 retry during load
    repeat (40) @(negedge clk);
    slv_req = 1; #1;
    push("R2 retry while busy", 9, 64'd1);
    flush();
    @(negedge clk); slv_req = 0; #1;
    push("R2 no retry without request", 9, 64'd0);
    flush();

    // R1 restart mid-load
    repeat (600) @(negedge clk);
    @(negedge clk); rst = 1;
    @(negedge clk);
    push("R1 busy during mid-load reset", 7, 64'd1);
    flush();
    @(negedge clk); rst = 0;
    @(negedge clk);
    push("R1 busy after restart", 7, 64'd1);
    flush();
    wait_idle();
    push("R1 load finished", 7, 64'd0);
    flush();
    expect_loaded("pattern A", seed);
    slv_req = 1; #1;
    push("R2 no retry when idle", 9, 64'd0);
    flush();
    slv_req = 0;

    // R8 locked after load
    u_keep = uid;
    sw_write(1'b1, 32'hDEAD_BEEF);
    sw_write(1'b0, 32'h1234_5678);
    push("R8 uid locked", 0, u_keep);
    flush();
    repeat (100) @(negedge clk);
    push("R10 busy stays low", 7, 64'd0);
    flush();

    // absent EEPROM
    present = 0;
    do_reset(3);
    repeat (20) @(negedge clk);
    sw_write(1'b1, 32'hAAAA_5555);
    wait_idle();
    push("R1 absent load finished", 7, 64'd0);
    push("R9 write while busy ignored", 0, 64'd0);
    push("R6 max_lat default", 3, 64'd4);
    push("R6 min_gnt default", 4, 64'd2);
    push("R6 vendor default", 1, 64'(DV));
    push("R6 subsys default", 2, 64'(DS));
    push("R6 en_flags default", 5, 64'd0);
    push("R6 single stop", 16, 64'd1);
    push("R6 no read", 12, 64'd0);
    push("R7 absent flag", 6, 64'd0);
    push("R7 absent ver_word", 8, 64'd0);
    push("R10 lines idle absent", 10, 64'd1);
    flush();
    sw_write(1'b1, 32'hCAFE_F00D);
    push("R9 upper write", 0, 64'hCAFE_F00D_0000_0000);
    flush();
    sw_write(1'b0, 32'h0BAD_1DEA);
    push("R9 lower write", 0, 64'hCAFE_F00D_0BAD_1DEA);
    flush();

    // second pattern
    present = 1;
    seed = 8'hC3;
    do_reset(2);
    @(negedge clk);
    push("R5 uid cleared by reset", 0, 64'd0);
    flush();
    wait_idle();
    expect_loaded("pattern B", seed);
    u_keep = uid;
    sw_write(1'b0, 32'h0);
    push("R8 uid locked B", 0, u_keep);
    flush();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule